// File: doc/BRIEF.md
# LCD Panel Drive Timing Generator

This block sequences the signals that scan a passive dot-matrix LCD panel. Each display line is made of a programmable number of 4-bit column nibbles followed by a fixed horizontal blanking gap. During the data part, every nibble is fetched from the display fetch path through a request strobe. The nibble is then presented to the column drivers with a shift clock whose falling edge is the capture point. During the gap the shift clock rests, and the block issues a row shift clock pulse followed by a line latch pulse.

Across lines, the block counts a programmable number of lines per frame. It raises the row frame marker for the whole last line and drives an AC-inversion waveform with one of two periods. A cascade clock advances the column drivers' enable chain once for every sixteen shift pulses.

A sleep request blanks the panel at a frame boundary: the display-on output drops one to two frames after the request is taken. Releasing the request restarts the scan from the first line.

Top module: `lcd_panel_timing`

## Requirements
- R1: Each nibble occupies two clock cycles: the shift clock is high in the first and low in the second. The column data output changes only on the first cycle, and it carries the `nib_i` value that was present in the cycle `nib_req_o` was high. `nib_req_o` is high exactly one cycle before each high shift-clock cycle.
- R2: A line lasts 2·W + 4 cycles, where W is `cfg_nibs` and the value 0 is treated as 1. The shift clock is low during the 4 blanking cycles.
- R3: The line latch is high for exactly one cycle per line, in blanking cycle 2 (line position 2·W + 1).
- R4: The chain clock is high together with the 16th, 32nd, … shift pulse of a line (nibble indices 15, 31, …, counted from 0). The count restarts on every line.
- R5: A frame has N = `cfg_duty` + 1 lines, where a `cfg_duty` of 0 is treated as 1, which gives 2 to 256 lines. The row frame marker is high for every cycle of the last line and low otherwise.
- R6: The row shift clock is high for one cycle per line, at position 2·W, the first blanking cycle.
- R7: The AC waveform is 0 in the first frame after a restart. With `wf_sel` = 0 it inverts at every frame boundary. With `wf_sel` = 1 it inverts at every second frame boundary.
- R8: A sleep request sampled high while running is taken. The display-on output then stays high until the second frame boundary that follows and drops in the cycle after it. From then on the shift clock, chain clock, line latch, row clock, frame marker, AC waveform and column data are all 0.
- R9: If the sleep request falls before the display-on output drops, the request is abandoned. The scan continues without disturbance and display-on stays high.
- R10: When the sleep request falls while blanked, display-on rises one cycle later. The scan resumes from position 0 of line 0 with the AC waveform at 0.
- R11: While reset is held, every output other than `nib_req_o` is 0, except display-on, which is 1. The first cycle after reset is released is position 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_nibs | input | NIB_W | Column nibbles per line (0 acts as 1) |
| cfg_duty | input | DUTY_W | Lines per frame minus one (0 acts as 1) |
| wf_sel | input | 1 | AC waveform period select |
| sleep_i | input | 1 | Sleep request, level |
| nib_i | input | 4 | Column nibble from the fetch path |
| nib_req_o | output | 1 | Nibble request; `nib_i` is captured at the end of this cycle |
| col_data_o | output | 4 | Column data to the column drivers |
| col_shclk_o | output | 1 | Column shift clock, falling edge active |
| chain_clk_o | output | 1 | Column enable-chain cascade clock |
| line_latch_o | output | 1 | Line latch pulse |
| row_shclk_o | output | 1 | Row shift clock, falling edge active |
| row_frame_o | output | 1 | Frame marker for the row driver chain |
| ac_wave_o | output | 1 | AC drive waveform |
| disp_on_o | output | 1 | Display-on, low while blanked |

## Verification
The scan is exercised with several geometries. A 20-nibble line over three lines tests a single cascade pulse per line. A 33-nibble line with the duty clamped to two lines tests two cascade pulses and the minimum frame. A one-nibble line, clamped from zero, over 256 lines stresses the shortest line and the longest frame. The two waveform selects are run on different frame counts so that the two periods can be told apart. A sleep request that is withdrawn after one frame boundary is separated from one held through two boundaries, and the bench follows the latter through wake-up to show the scan restarting at line 0.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

    localparam int NIB_BITS = 4;

    typedef enum logic [1:0] {
        PWR_RUN   = 2'd0,
        PWR_DRAIN = 2'd1,
        PWR_OFF   = 2'd2
    } pwr_state_e;

    typedef struct packed {
        logic shclk;
        logic chain;
        logic latch;
        logic row_clk;
        logic frame;
        logic ac;
        logic on;
    } drive_t;

    localparam drive_t DRIVE_RESET = '{
        shclk: 1'b0, chain: 1'b0, latch: 1'b0, row_clk: 1'b0,
        frame: 1'b0, ac: 1'b0, on: 1'b1
    };

    // AC phase from the frame counter: bit 0 flips every frame, bit 1 every two.
    function automatic logic wave_pick(input logic sel, input logic [1:0] fcnt);
        return sel ? fcnt[1] : fcnt[0];
    endfunction

endpackage

// File: rtl/lcd_tg_scan.sv
module lcd_tg_scan #(
    parameter int HCNT_W = 10,
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [HCNT_W-1:0] last_h,
    input  logic [DUTY_W-1:0] last_v,
    output logic [HCNT_W-1:0] hcnt,
    output logic [DUTY_W-1:0] vcnt,
    output logic [1:0]        fcnt,
    output logic              frame_end
);

    logic line_end;

    assign line_end  = run && (hcnt == last_h);
    assign frame_end = line_end && (vcnt == last_v);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            hcnt <= '0;
            vcnt <= '0;
            fcnt <= '0;
        end else if (line_end) begin
            hcnt <= '0;
            if (frame_end) begin
                vcnt <= '0;
                fcnt <= fcnt + 2'd1;
            end else begin
                vcnt <= vcnt + 1'b1;
            end
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

endmodule

// File: rtl/lcd_tg_power.sv
module lcd_tg_power
    import lcd_tg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sleep_req,
    input  logic frame_end,
    output logic run
);

    pwr_state_e state;
    logic       seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PWR_RUN;
            seen  <= 1'b0;
        end else begin
            case (state)
                PWR_RUN: begin
                    if (sleep_req) begin
                        state <= PWR_DRAIN;
                        seen  <= 1'b0;
                    end
                end
                PWR_DRAIN: begin
                    if (!sleep_req) begin
                        state <= PWR_RUN;
                    end else if (frame_end) begin
                        if (seen) begin
                            state <= PWR_OFF;
                        end
                        seen <= 1'b1;
                    end
                end
                PWR_OFF: begin
                    if (!sleep_req) begin
                        state <= PWR_RUN;
                    end
                end
                default: state <= PWR_RUN;
            endcase
        end
    end

    assign run = (state != PWR_OFF);

endmodule

// File: rtl/lcd_tg_drive.sv
module lcd_tg_drive
    import lcd_tg_pkg::*;
#(
    parameter int HCNT_W    = 10,
    parameter int DUTY_W    = 8,
    parameter int CHAIN_DIV = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic [HCNT_W-1:0]   hcnt,
    input  logic [DUTY_W-1:0]   vcnt,
    input  logic [1:0]          fcnt,
    input  logic [HCNT_W-1:0]   data_len,
    input  logic [DUTY_W-1:0]   last_v,
    input  logic                wf_sel,
    input  logic [NIB_BITS-1:0] nib_i,
    output logic                nib_req,
    output logic [NIB_BITS-1:0] col_data,
    output drive_t              drv
);

    localparam int CHAIN_BITS = $clog2(CHAIN_DIV);

    drive_t              drv_d;
    drive_t              drv_q;
    logic [NIB_BITS-1:0] col_q;
    logic [HCNT_W-2:0]   nib_idx;
    logic                in_data;

    assign nib_idx = hcnt[HCNT_W-1:1];
    assign in_data = (hcnt < data_len);

    always_comb begin
        drv_d.shclk   = run && in_data && !hcnt[0];
        drv_d.chain   = drv_d.shclk && (&nib_idx[CHAIN_BITS-1:0]);
        drv_d.row_clk = run && (hcnt == data_len);
        drv_d.latch   = run && (hcnt == data_len + HCNT_W'(1));
        drv_d.frame   = run && (vcnt == last_v);
        drv_d.ac      = run && wave_pick(wf_sel, fcnt);
        drv_d.on      = run;
    end

    assign nib_req = drv_d.shclk;

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q <= DRIVE_RESET;
            col_q <= '0;
        end else begin
            drv_q <= drv_d;
            if (!run) begin
                col_q <= '0;
            end else if (nib_req) begin
                col_q <= nib_i;
            end
        end
    end

    assign drv      = drv_q;
    assign col_data = col_q;

endmodule

// File: rtl/lcd_panel_timing.sv
module lcd_panel_timing
    import lcd_tg_pkg::*;
#(
    parameter int NIB_W     = 8,
    parameter int DUTY_W    = 8,
    parameter int HBLANK    = 4,
    parameter int CHAIN_DIV = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NIB_W-1:0]    cfg_nibs,
    input  logic [DUTY_W-1:0]   cfg_duty,
    input  logic                wf_sel,
    input  logic                sleep_i,
    input  logic [3:0]          nib_i,
    output logic                nib_req_o,
    output logic [3:0]          col_data_o,
    output logic                col_shclk_o,
    output logic                chain_clk_o,
    output logic                line_latch_o,
    output logic                row_shclk_o,
    output logic                row_frame_o,
    output logic                ac_wave_o,
    output logic                disp_on_o
);

    localparam int HCNT_W = NIB_W + 2;

    logic [NIB_W-1:0]  nibs_eff;
    logic [HCNT_W-1:0] data_len;
    logic [HCNT_W-1:0] last_h;
    logic [DUTY_W-1:0] last_v;
    logic [HCNT_W-1:0] hcnt;
    logic [DUTY_W-1:0] vcnt;
    logic [1:0]        fcnt;
    logic              frame_end;
    logic              run;
    drive_t            drv;

    assign nibs_eff = (cfg_nibs == '0) ? NIB_W'(1) : cfg_nibs;
    assign data_len = {1'b0, nibs_eff, 1'b0};
    assign last_h   = data_len + HCNT_W'(HBLANK - 1);
    assign last_v   = (cfg_duty == '0) ? DUTY_W'(1) : cfg_duty;

    lcd_tg_scan #(
        .HCNT_W (HCNT_W),
        .DUTY_W (DUTY_W)
    ) u_scan (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .last_h    (last_h),
        .last_v    (last_v),
        .hcnt      (hcnt),
        .vcnt      (vcnt),
        .fcnt      (fcnt),
        .frame_end (frame_end)
    );

    lcd_tg_power u_power (
        .clk       (clk),
        .rst       (rst),
        .sleep_req (sleep_i),
        .frame_end (frame_end),
        .run       (run)
    );

    lcd_tg_drive #(
        .HCNT_W    (HCNT_W),
        .DUTY_W    (DUTY_W),
        .CHAIN_DIV (CHAIN_DIV)
    ) u_drive (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .hcnt     (hcnt),
        .vcnt     (vcnt),
        .fcnt     (fcnt),
        .data_len (data_len),
        .last_v   (last_v),
        .wf_sel   (wf_sel),
        .nib_i    (nib_i),
        .nib_req  (nib_req_o),
        .col_data (col_data_o),
        .drv      (drv)
    );

    assign col_shclk_o  = drv.shclk;
    assign chain_clk_o  = drv.chain;
    assign line_latch_o = drv.latch;
    assign row_shclk_o  = drv.row_clk;
    assign row_frame_o  = drv.frame;
    assign ac_wave_o    = drv.ac;
    assign disp_on_o    = drv.on;

endmodule

// File: rtl/lcd_tg_checker.sv
module lcd_tg_checker (
    input logic       clk,
    input logic       rst,
    input logic [3:0] nib_i,
    input logic       nib_req_o,
    input logic [3:0] col_data_o,
    input logic       col_shclk_o,
    input logic       chain_clk_o,
    input logic       line_latch_o,
    input logic       row_shclk_o,
    input logic       row_frame_o,
    input logic       disp_on_o
);

    a_r1_req_then_shift: assert property (@(posedge clk) disable iff (rst)
        nib_req_o |=> col_shclk_o);

    a_r1_data_from_req: assert property (@(posedge clk) disable iff (rst)
        nib_req_o |=> (col_data_o == $past(nib_i)));

    a_r1_data_held_at_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(col_shclk_o) |-> $stable(col_data_o));

    a_r2_shift_rests_after_latch: assert property (@(posedge clk) disable iff (rst)
        line_latch_o |=> !col_shclk_o);

    a_r3_latch_one_cycle: assert property (@(posedge clk) disable iff (rst)
        line_latch_o |=> !line_latch_o);

    a_r4_chain_inside_shift: assert property (@(posedge clk) disable iff (rst)
        chain_clk_o |-> col_shclk_o);

    a_r6_row_clk_then_latch: assert property (@(posedge clk) disable iff (rst)
        row_shclk_o |=> line_latch_o);

    a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !disp_on_o |-> (!col_shclk_o && !chain_clk_o && !line_latch_o &&
                        !row_shclk_o && !row_frame_o && (col_data_o == 4'd0)));

endmodule

bind lcd_panel_timing lcd_tg_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .nib_i        (nib_i),
    .nib_req_o    (nib_req_o),
    .col_data_o   (col_data_o),
    .col_shclk_o  (col_shclk_o),
    .chain_clk_o  (chain_clk_o),
    .line_latch_o (line_latch_o),
    .row_shclk_o  (row_shclk_o),
    .row_frame_o  (row_frame_o),
    .disp_on_o    (disp_on_o)
);

// File: tb/sim_lcd_panel_timing.sv
`timescale 1ns/1ps
module sim_lcd_panel_timing;

    localparam int HB = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cfg_nibs = 8'd0;
    logic [7:0] cfg_duty = 8'd0;
    logic       wf_sel = 1'b0;
    logic       sleep_i = 1'b0;
    logic [3:0] nib_i = 4'd0;
    logic       nib_req_o;
    logic [3:0] col_data_o;
    logic       col_shclk_o, chain_clk_o, line_latch_o, row_shclk_o;
    logic       row_frame_o, ac_wave_o, disp_on_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int g = 0;
    int W = 1;
    int N = 2;
    logic [3:0] cur_nib = 4'd0;
    logic [3:0] prev_nib = 4'd0;

    always #2.5 clk = ~clk;

    lcd_panel_timing u0 (
        .clk          (clk),
        .rst          (rst),
        .cfg_nibs     (cfg_nibs),
        .cfg_duty     (cfg_duty),
        .wf_sel       (wf_sel),
        .sleep_i      (sleep_i),
        .nib_i        (nib_i),
        .nib_req_o    (nib_req_o),
        .col_data_o   (col_data_o),
        .col_shclk_o  (col_shclk_o),
        .chain_clk_o  (chain_clk_o),
        .line_latch_o (line_latch_o),
        .row_shclk_o  (row_shclk_o),
        .row_frame_o  (row_frame_o),
        .ac_wave_o    (ac_wave_o),
        .disp_on_o    (disp_on_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected below 150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Hold reset with a new configuration, check the reset state (R11), release.
    task automatic do_reset(input int nibs, input int duty, input bit sel);
        rst = 1'b1;
        sleep_i = 1'b0;
        cfg_nibs = 8'(nibs);
        cfg_duty = 8'(duty);
        wf_sel = sel;
        W = (nibs == 0) ? 1 : nibs;
        N = ((duty == 0) ? 1 : duty) + 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11", "shclk in reset", col_shclk_o, 0);
        check("R11", "latch in reset", line_latch_o, 0);
        check("R11", "frame in reset", row_frame_o, 0);
        check("R11", "data in reset", col_data_o, 0);
        check("R11", "disp_on in reset", disp_on_o, 1);
        check("R11", "ac in reset", ac_wave_o, 0);
        rst = 1'b0;
    endtask

    // One clock; then compare outputs with the model at scan index idx (on=1) or the blank state.
    task automatic step(input bit slp, input bit on, input int idx, input bit chk_req);
        int L, pos, line, fr, npos;
        bit sh, exp_req;
        prev_nib = cur_nib;
        cur_nib = 4'(g * 5 + 3);
        g++;
        sleep_i = slp;
        nib_i = cur_nib;
        @(posedge clk);
        @(negedge clk);
        L = 2 * W + HB;
        pos = idx % L;
        line = (idx / L) % N;
        fr = idx / (L * N);
        if (on) begin
            sh = (pos < 2 * W) && (pos % 2 == 0);
            check((pos < 2 * W) ? "R1" : "R2", "shclk", col_shclk_o, int'(sh));
            check("R4", "chain", chain_clk_o, int'(sh && ((pos / 2) % 16 == 15)));
            check("R3", "latch", line_latch_o, int'(pos == 2 * W + 1));
            check("R6", "row clk", row_shclk_o, int'(pos == 2 * W));
            check("R5", "frame", row_frame_o, int'(line == N - 1));
            check("R7", "ac", ac_wave_o, wf_sel ? (fr / 2) % 2 : fr % 2);
            check("R8", "disp_on", disp_on_o, 1);
            if (pos < 2 * W) begin
                check("R1", "col data", col_data_o, (pos % 2 == 0) ? cur_nib : prev_nib);
            end
            if (chk_req) begin
                npos = (idx + 1) % L;
                exp_req = (npos < 2 * W) && (npos % 2 == 0);
                check("R1", "nib_req", nib_req_o, int'(exp_req));
            end
        end else begin
            check("R8", "disp_on off", disp_on_o, 0);
            check("R8", "shclk off", col_shclk_o, 0);
            check("R8", "latch off", line_latch_o, 0);
            check("R8", "row clk off", row_shclk_o, 0);
            check("R8", "frame off", row_frame_o, 0);
            check("R8", "ac off", ac_wave_o, 0);
            check("R8", "data off", col_data_o, 0);
        end
    endtask

    // 20 nibbles, 3 lines, waveform every frame.
    task automatic t_basic();
        do_reset(20, 2, 1'b0);
        for (int i = 0; i < 3 * 44 * 3 + 10; i++) step(1'b0, 1'b1, i, 1'b1);
    endtask

    // 33 nibbles (two chain pulses), duty 0 clamped to 2 lines, waveform every 2 frames.
    task automatic t_wide_min_duty();
        do_reset(33, 0, 1'b1);
        for (int i = 0; i < 70 * 2 * 5; i++) step(1'b0, 1'b1, i, 1'b1);
    endtask

    // Width 0 clamped to 1 nibble, 256 lines per frame.
    task automatic t_narrow_max_duty();
        do_reset(0, 255, 1'b1);
        for (int i = 0; i < 6 * 256 * 3; i++) step(1'b0, 1'b1, i, 1'b1);
    endtask

    // Sleep withdrawn after one boundary (R9), then held to blanking and released (R8, R10).
    task automatic t_sleep();
        do_reset(4, 1, 1'b0); // L = 12, N = 2, frame = 24 cycles
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1, i, 1'b0);
        for (int i = 10; i < 30; i++) step(1'b1, 1'b1, i, 1'b0);
        for (int i = 30; i < 61; i++) begin
            step(1'b0, 1'b1, i, 1'b0);
            check("R9", "disp_on after withdraw", disp_on_o, 1);
        end
        for (int i = 61; i <= 95; i++) step(1'b1, 1'b1, i, 1'b0);
        for (int i = 96; i <= 110; i++) step(1'b1, 1'b0, 0, 1'b0);
        step(1'b0, 1'b0, 0, 1'b0);
        for (int j = 0; j < 60; j++) begin
            step(1'b0, 1'b1, j, 1'b0);
            if (j == 0) begin
                check("R10", "restart shclk", col_shclk_o, 1);
                check("R10", "restart disp_on", disp_on_o, 1);
                check("R10", "restart ac", ac_wave_o, 0);
            end
        end
    endtask

    initial begin
        t_basic();
        t_wide_min_duty();
        t_narrow_max_duty();
        t_sleep();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule